// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a synchronous model of the command engine found in a byte-wide flash memory that erases in 256-byte sectors. A host issues decoded write and read strobes with a 19-bit address and a byte of data. Byte programming, sector erase and chip erase each need two writes: one that arms the operation and one that starts it. A single write enters or leaves an identification mode. Once an operation starts, an internal cycle counter times it. While the counter runs, reads return status bits instead of array contents.

The storage is a small register array of `2**MEM_AW` bytes. Only the low `MEM_AW` bits of an address reach the array, so higher addresses alias onto it. A lock input stops the three destructive operations from being armed. Durations are given in clock cycles through parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After reset, or after a reset part-way through an operation, `op_busy` is 0, `bus_rdata` is 00h, the controller is in read mode and every byte reads FFh.
- R2: A write of 10h arms programming. The next write (other than FFh) starts programming at its address. At the end of the operation the stored byte is the old byte AND the written byte. Array index = address bits [MEM_AW-1:0].
- R3: A write of 20h followed by D0h erases one sector to FFh. The sector is chosen by array index bits [MEM_AW-1:8] of the D0h write, and the low 8 bits are ignored. Other sectors keep their contents.
- R4: A write of 30h followed by a second 30h sets every byte of the array to FFh.
- R5: A write of FFh in any armed state aborts. No operation starts, memory is unchanged and the controller returns to read mode.
- R6: A write of 90h enters identification mode. In this mode a read at address 0 returns BFh, a read at address 1 returns 04h, and a read at any other address returns array data. Writing FFh or arming a command leaves the mode.
- R7: `op_busy` rises at the clock edge that samples the starting write. It stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles, depending on the operation.
- R8: A read while busy returns bit 7 as the complement of the target byte's final bit 7 (FFh for erase), and bits 5..0 as zero, at any address.
- R9: Within one operation, bit 6 of busy reads is 0 on the first read and inverts on each later read. Once busy falls, reads return array data.
- R10: While `prot_lock` is 1, the writes 10h, 20h and 30h are ignored in read and identification mode. Identification entry and FFh still work.
- R11: An armed erase that receives a byte other than its execute code (D0h for sector erase, 30h for chip erase) returns to read mode and starts nothing.
- R12: Writes that arrive while `op_busy` is 1 have no effect, including on the command state after completion.
- R13: `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data or command byte |
| prot_lock | input | 1 | Blocks arming of program and erase |
| bus_rdata | output | 8 | Registered read data or status |
| op_busy | output | 1 | High while a timed operation runs |

## Verification
The hardest state to reach is a read that lands inside the busy window of a specific operation. The bench must start an operation and then issue reads that are counted from the starting write, so that each read meets a known toggle phase and a known polarity of the polled bit. It also covers a command sent during the busy window: the bench sends 10h while an erase runs, and then sends a byte write once the erase has finished. The final busy flag and the array contents show whether the stray arm was dropped. For the protection cases, the same pair of writes is sent with the lock set, and the bench confirms at the ports that no operation started.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes, identification bytes and state types for the
// flash command controller. Assumes byte-wide commands.
package flash_cmd_pkg;
    localparam logic [7:0] CMD_PROG_ARM  = 8'h10;
    localparam logic [7:0] CMD_SECT_ARM  = 8'h20;
    localparam logic [7:0] CMD_SECT_GO   = 8'hD0;
    localparam logic [7:0] CMD_CHIP_ARM  = 8'h30;
    localparam logic [7:0] CMD_CHIP_GO   = 8'h30;
    localparam logic [7:0] CMD_ABORT     = 8'hFF;
    localparam logic [7:0] CMD_IDENT     = 8'h90;
    localparam logic [7:0] ID_MAKER      = 8'hBF;
    localparam logic [7:0] ID_PART       = 8'h04;
    localparam logic [7:0] ERASED        = 8'hFF;

    typedef enum logic [2:0] {
        M_READ,
        M_IDENT,
        M_PROG_ARM,
        M_SECT_ARM,
        M_CHIP_ARM
    } cmd_mode_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_e;
endpackage

// File: rtl/flash_cmd_decode.sv
// Command decoder: walks the setup/execute sequences and emits a one-cycle
// launch code when an operation must start.
// Assumes: writes are single-cycle strobes; the timer reports busy.
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_byte,
    input  logic       lock,
    input  logic       busy,
    output cmd_mode_e  mode,
    output op_kind_e   launch
);
    cmd_mode_e mode_nxt;

    // Next mode and launch code from the current mode and the write byte.
    always_comb begin
        mode_nxt = mode;
        launch   = OP_NONE;
        if (wr_stb && !busy) begin
            case (mode)
                M_READ, M_IDENT: begin
                    case (wr_byte)
                        CMD_PROG_ARM: if (!lock) mode_nxt = M_PROG_ARM;
                        CMD_SECT_ARM: if (!lock) mode_nxt = M_SECT_ARM;
                        CMD_CHIP_ARM: if (!lock) mode_nxt = M_CHIP_ARM;
                        CMD_IDENT:    mode_nxt = M_IDENT;
                        CMD_ABORT:    mode_nxt = M_READ;
                        default:      mode_nxt = mode;
                    endcase
                end
                M_PROG_ARM: begin
                    mode_nxt = M_READ;
                    if (wr_byte != CMD_ABORT) launch = OP_PROG;
                end
                M_SECT_ARM: begin
                    mode_nxt = M_READ;
                    if (wr_byte == CMD_SECT_GO) launch = OP_SECT;
                end
                M_CHIP_ARM: begin
                    mode_nxt = M_READ;
                    if (wr_byte == CMD_CHIP_GO) launch = OP_CHIP;
                end
                default: mode_nxt = M_READ;
            endcase
        end
    end

    // Mode register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= M_READ;
        else        mode <= mode_nxt;
    end

    // R12
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb) |=> $stable(mode));

    // R10
    lock_blocks_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_stb && (mode == M_READ || mode == M_IDENT))
        |=> !(mode == M_PROG_ARM || mode == M_SECT_ARM || mode == M_CHIP_ARM));
endmodule

// File: rtl/flash_op_timer.sv
// Operation timer: holds busy for a number of cycles chosen by the launch
// code and pulses done in the last busy cycle.
// Assumes: every duration parameter is at least 1.
module flash_op_timer
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC = 40,
    parameter int SECT_CYC = 400,
    parameter int CHIP_CYC = 2000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  op_kind_e launch,
    output logic     busy,
    output logic     done
);
    localparam int LONG_A  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int LONGEST = (LONG_A > CHIP_CYC) ? LONG_A : CHIP_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;

    // Pick the start count for the operation being launched.
    always_comb begin
        case (launch)
            OP_PROG: load_val = CNT_W'(PROG_CYC - 1);
            OP_SECT: load_val = CNT_W'(SECT_CYC - 1);
            OP_CHIP: load_val = CNT_W'(CHIP_CYC - 1);
            default: load_val = '0;
        endcase
    end

    // Count down while busy; drop busy after the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (launch != OP_NONE) begin
            busy   <= 1'b1;
            remain <= load_val;
        end
    end

    assign done = busy && (remain == '0);

    // R12
    launch_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch != OP_NONE) |-> !busy);

    // R7
    busy_from_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(launch) != OP_NONE));
endmodule

// File: rtl/flash_byte_array.sv
// Byte storage: latches the target of a launched operation and, when done
// arrives, applies program (AND), sector erase or chip erase.
// Assumes: MEM_AW > SECT_AW; launch never coincides with done.
module flash_byte_array
    import flash_cmd_pkg::*;
#(
    parameter int MEM_AW  = 10,
    parameter int SECT_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_kind_e          launch,
    input  logic [MEM_AW-1:0] op_idx,
    input  logic [7:0]        op_data,
    input  logic              done,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    output logic              poll_msb
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0]        mem [DEPTH];
    logic [MEM_AW-1:0] tgt_idx;
    op_kind_e          pend_op;
    logic [7:0]        poll_byte;

    // Capture target, kind and final byte value at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_idx   <= '0;
            pend_op   <= OP_NONE;
            poll_byte <= ERASED;
        end else if (launch != OP_NONE) begin
            tgt_idx   <= op_idx;
            pend_op   <= launch;
            poll_byte <= (launch == OP_PROG) ? (mem[op_idx] & op_data) : ERASED;
        end
    end

    // Apply the pending operation to every byte it covers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= ERASED;
            end else if (done) begin
                case (pend_op)
                    OP_PROG: if (tgt_idx == MEM_AW'(i)) mem[i] <= poll_byte;
                    OP_SECT: if ((tgt_idx >> SECT_AW) == (MEM_AW'(i) >> SECT_AW))
                                 mem[i] <= ERASED;
                    OP_CHIP: mem[i] <= ERASED;
                    default: ;
                endcase
            end
        end
    end

    assign rd_byte  = mem[rd_idx];
    assign poll_msb = poll_byte[7];

    // R3
    sect_erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend_op == OP_SECT) |=> (mem[tgt_idx] == ERASED));

    // R2
    prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend_op == OP_PROG) |=> ((mem[tgt_idx] & ~$past(mem[tgt_idx])) == 8'h00));

    // R4
    chip_erase_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend_op == OP_CHIP) |=> (mem[0] == ERASED && mem[DEPTH-1] == ERASED));
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command controller: joins decoder, timer and array and
// registers read data, substituting status or identification bytes.
// Assumes: single-cycle read and write strobes from a decoded host bus.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int MEM_AW   = 10,
    parameter int SECT_AW  = 8,
    parameter int PROG_CYC = 40,
    parameter int SECT_CYC = 400,
    parameter int CHIP_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              prot_lock,
    output logic [7:0]        bus_rdata,
    output logic              op_busy
);
    cmd_mode_e  mode;
    op_kind_e   launch;
    logic       done;
    logic       poll_msb;
    logic       tog;
    logic [7:0] arr_byte;

    flash_cmd_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (bus_wr),
        .wr_byte (bus_wdata),
        .lock    (prot_lock),
        .busy    (op_busy),
        .mode    (mode),
        .launch  (launch)
    );

    flash_op_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (op_busy),
        .done   (done)
    );

    flash_byte_array #(
        .MEM_AW  (MEM_AW),
        .SECT_AW (SECT_AW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .op_idx   (bus_addr[MEM_AW-1:0]),
        .op_data  (bus_wdata),
        .done     (done),
        .rd_idx   (bus_addr[MEM_AW-1:0]),
        .rd_byte  (arr_byte),
        .poll_msb (poll_msb)
    );

    // Registered read path: status while busy, else identification or array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
            tog       <= 1'b0;
        end else begin
            if (launch != OP_NONE) tog <= 1'b0;
            if (bus_rd) begin
                if (op_busy) begin
                    bus_rdata <= {~poll_msb, tog, 6'b000000};
                    tog       <= ~tog;
                end else if (mode == M_IDENT && bus_addr == '0) begin
                    bus_rdata <= ID_MAKER;
                end else if (mode == M_IDENT && bus_addr == ADDR_W'(1)) begin
                    bus_rdata <= ID_PART;
                end else begin
                    bus_rdata <= arr_byte;
                end
            end
        end
    end

    // R8
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && bus_rd) |=> (bus_rdata[7] == ~$past(poll_msb)));

    // R9
    toggle_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && bus_rd && $past(op_busy) && $past(bus_rd))
        |=> (bus_rdata[6] != $past(bus_rdata[6])));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int ADDR_W   = 19;
    localparam int PROG_CYC = 40;
    localparam int SECT_CYC = 400;
    localparam int CHIP_CYC = 2000;
    localparam int NVEC     = 42;

    // Vector: {kind[2], req[4], addr[19], data[8], expect[8]}
    // kind 0 = write, 1 = read and compare, 2 = wait for idle, 3 = compare busy
    localparam logic [40:0] VEC [NVEC] = '{
        // R2 program, then AND on reprogram, then second sector
        {2'd0, 4'd2, 19'h00000, 8'h10, 8'h00},
        {2'd0, 4'd2, 19'h00005, 8'hA5, 8'h00},
        {2'd2, 4'd2, 19'h00000, 8'h00, 8'h00},
        {2'd1, 4'd2, 19'h00005, 8'h00, 8'hA5},
        {2'd0, 4'd2, 19'h00000, 8'h10, 8'h00},
        {2'd0, 4'd2, 19'h00005, 8'h3C, 8'h00},
        {2'd2, 4'd2, 19'h00000, 8'h00, 8'h00},
        {2'd1, 4'd2, 19'h00005, 8'h00, 8'h24},
        {2'd0, 4'd2, 19'h00000, 8'h10, 8'h00},
        {2'd0, 4'd2, 19'h00105, 8'h0F, 8'h00},
        {2'd2, 4'd2, 19'h00000, 8'h00, 8'h00},
        {2'd1, 4'd2, 19'h00105, 8'h00, 8'h0F},
        // R3 sector 0 erase via low-bit-ignored address, sector 1 kept
        {2'd0, 4'd3, 19'h00000, 8'h20, 8'h00},
        {2'd0, 4'd3, 19'h000FF, 8'hD0, 8'h00},
        {2'd2, 4'd3, 19'h00000, 8'h00, 8'h00},
        {2'd1, 4'd3, 19'h00005, 8'h00, 8'hFF},
        {2'd1, 4'd3, 19'h00105, 8'h00, 8'h0F},
        // R6 identification mode entry, reads, exit
        {2'd0, 4'd6, 19'h00000, 8'h90, 8'h00},
        {2'd1, 4'd6, 19'h00000, 8'h00, 8'hBF},
        {2'd1, 4'd6, 19'h00001, 8'h00, 8'h04},
        {2'd1, 4'd6, 19'h00105, 8'h00, 8'h0F},
        {2'd0, 4'd6, 19'h00000, 8'hFF, 8'h00},
        {2'd1, 4'd6, 19'h00000, 8'h00, 8'hFF},
        // R5 abort after program arm
        {2'd0, 4'd5, 19'h00000, 8'h10, 8'h00},
        {2'd0, 4'd5, 19'h00000, 8'hFF, 8'h00},
        {2'd3, 4'd5, 19'h00000, 8'h00, 8'h00},
        {2'd0, 4'd5, 19'h00105, 8'h00, 8'h00},
        {2'd1, 4'd5, 19'h00105, 8'h00, 8'h0F},
        // R11 wrong execute byte after sector arm
        {2'd0, 4'd11, 19'h00000, 8'h20, 8'h00},
        {2'd0, 4'd11, 19'h00105, 8'h55, 8'h00},
        {2'd3, 4'd11, 19'h00000, 8'h00, 8'h00},
        {2'd1, 4'd11, 19'h00105, 8'h00, 8'h0F},
        // R4 chip erase
        {2'd0, 4'd4, 19'h00000, 8'h30, 8'h00},
        {2'd0, 4'd4, 19'h00000, 8'h30, 8'h00},
        {2'd3, 4'd4, 19'h00000, 8'h00, 8'h01},
        {2'd2, 4'd4, 19'h00000, 8'h00, 8'h00},
        {2'd1, 4'd4, 19'h00105, 8'h00, 8'hFF},
        {2'd1, 4'd4, 19'h00005, 8'h00, 8'hFF},
        // R2 high address bits alias onto the array
        {2'd0, 4'd2, 19'h00000, 8'h10, 8'h00},
        {2'd0, 4'd2, 19'h40005, 8'h77, 8'h00},
        {2'd2, 4'd2, 19'h00000, 8'h00, 8'h00},
        {2'd1, 4'd2, 19'h00005, 8'h00, 8'h77}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = 8'h00;
    logic              prot_lock = 1'b0;
    logic [7:0]        bus_rdata;
    logic              op_busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W   (ADDR_W),
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .prot_lock (prot_lock),
        .bus_rdata (bus_rdata),
        .op_busy   (op_busy)
    );

    task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp,
                       input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && op_busy; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [40:0] v;
        logic [7:0]  rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(1, {7'b0, op_busy}, 8'h00, "busy after reset");
        chk(1, bus_rdata, 8'h00, "rdata after reset");
        do_read(19'h003FF, rd);
        chk(1, rd, 8'hFF, "erased after reset");

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            case (v[40:39])
                2'd0: do_write(v[34:16], v[15:8]);
                2'd1: begin
                    do_read(v[34:16], rd);
                    chk(int'(v[38:35]), rd, v[7:0], $sformatf("vector %0d read", i));
                end
                2'd2: wait_idle();
                default: chk(int'(v[38:35]), {7'b0, op_busy}, v[7:0],
                             $sformatf("vector %0d busy", i));
            endcase
        end

        // R7 exact program duration
        do_write(19'h0, 8'h10);
        do_write(19'h030, 8'h00);
        chk(7, {7'b0, op_busy}, 8'h01, "busy after launch");
        repeat (PROG_CYC - 1) @(negedge clk);
        chk(7, {7'b0, op_busy}, 8'h01, "busy in last cycle");
        @(negedge clk);
        chk(7, {7'b0, op_busy}, 8'h00, "busy cleared");
        do_read(19'h030, rd);
        chk(2, rd, 8'h00, "programmed 00");

        // R8 and R9: status reads during a program of 7Fh
        do_write(19'h0, 8'h10);
        do_write(19'h020, 8'h7F);
        do_read(19'h020, rd);
        chk(8, rd, 8'h80, "first poll read");
        do_read(19'h123, rd);
        chk(9, rd, 8'hC0, "second poll read toggles");
        do_read(19'h020, rd);
        chk(9, rd, 8'h80, "third poll read toggles back");
        wait_idle();
        do_read(19'h020, rd);
        chk(9, rd, 8'h7F, "array data after completion");

        // R8, R9 and R12: sector erase with a stray arm while busy
        do_write(19'h0, 8'h20);
        do_write(19'h200, 8'hD0);
        do_read(19'h200, rd);
        chk(8, rd, 8'h00, "erase poll read");
        do_read(19'h200, rd);
        chk(9, rd, 8'h40, "erase toggle");
        do_write(19'h0, 8'h10);
        wait_idle();
        do_write(19'h200, 8'h33);
        chk(12, {7'b0, op_busy}, 8'h00, "no launch from stray arm");
        do_read(19'h200, rd);
        chk(12, rd, 8'hFF, "byte untouched after stray arm");

        // R10 protection lock
        prot_lock = 1'b1;
        do_write(19'h0, 8'h10);
        do_write(19'h300, 8'h12);
        chk(10, {7'b0, op_busy}, 8'h00, "program blocked");
        do_read(19'h300, rd);
        chk(10, rd, 8'hFF, "byte unchanged under lock");
        do_write(19'h0, 8'h20);
        do_write(19'h005, 8'hD0);
        chk(10, {7'b0, op_busy}, 8'h00, "erase blocked");
        do_write(19'h0, 8'h90);
        do_read(19'h001, rd);
        chk(10, rd, 8'h04, "ident under lock");
        do_write(19'h0, 8'hFF);
        do_read(19'h001, rd);
        chk(10, rd, 8'hFF, "abort under lock leaves ident");
        prot_lock = 1'b0;

        // R13 read data holds
        do_read(19'h005, rd);
        chk(13, rd, 8'h77, "read value");
        repeat (3) @(negedge clk);
        chk(13, bus_rdata, 8'h77, "rdata held");

        // R1 reset during an operation
        do_write(19'h0, 8'h30);
        do_write(19'h0, 8'h30);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(1, {7'b0, op_busy}, 8'h00, "busy after mid reset");
        chk(1, bus_rdata, 8'h00, "rdata after mid reset");
        do_read(19'h005, rd);
        chk(1, rd, 8'hFF, "array after mid reset");

        finish_run();
    end
endmodule